// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer

This block is a timer that produces centre-aligned pulse-width modulation. A counter climbs from zero to a selectable ceiling, turns round and falls back to zero, and repeats. Each compare channel watches the count. When the count meets the channel's threshold on the rising slope, the output is driven one way. When it meets the threshold on the falling slope, the output is driven the other way. The pulses are therefore centred on the turning points, which suits motor bridges.

The ceiling comes from one of three fixed values, from a capture register, or from the active threshold of channel 0. Software writes reach a shadow copy of each threshold. The shadow is moved into the active threshold only when the counter steps onto its ceiling, so a change never lands part way through a period. The timer advances only on cycles where the timer-clock enable is high. Single-cycle pulses report the bottom, the ceiling (when the capture register sets it) and each channel's match.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: During and after reset the count is 0 and every output and flag is low. The first enabled step after reset goes to 1.
- R2: Each cycle with `tick_i` high moves the count one step. It rises to the ceiling, shows the ceiling for one step, falls to 0, shows 0 for one step, and rises again. Without `tick_i` the count holds.
- R3: `top_src_i` picks the ceiling: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the capture register, 4 gives channel 0's active threshold, and 5 to 7 give 0x00FF. Any ceiling below 3 acts as 3.
- R4: Each channel takes a 2-bit mode from `out_mode_i[2i+1:2i]`. In mode 2, a match is evaluated on the step that lands on the threshold. If the next step from that value goes up (this includes 0), the pin goes low. If it goes down (this includes the ceiling), the pin goes high. Mode 3 does the reverse. Modes 0 and 1 hold the pin low.
- R5: A threshold above the ceiling never matches, so the pin and the match flag stay unchanged.
- R6: `ovf_flag_o` is high for one clock after the step that lands on 0.
- R7: `cmp_flag_o[i]` is high for one clock after a step that lands on channel i's active threshold.
- R8: `capt_flag_o` is high for one clock after an upward step that lands on the ceiling, and only while `top_src_i` is 3.
- R9: When `wr_en_i` is high, `wr_sel_i` picks the target. Values 0 to NUM_CH-1 write that channel's shadow threshold. The value NUM_CH writes the capture register, which takes effect on the next clock. A shadow reaches the active threshold only on the upward step onto the ceiling. A match on that step uses the old threshold. A write in that same cycle is kept for the following period.
- R10: If the count is at or above the ceiling while rising, the next step goes down by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer-clock enable; one count step per high cycle |
| top_src_i | input | 3 | Ceiling source select |
| out_mode_i | input | 2*NUM_CH | Per-channel output mode, 2 bits each |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Write target: channel shadow or capture register |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| pwm_o | output | NUM_CH | PWM pins |
| ovf_flag_o | output | 1 | Bottom-reached pulse |
| capt_flag_o | output | 1 | Ceiling-reached pulse when the capture register sets the ceiling |
| cmp_flag_o | output | NUM_CH | Per-channel match pulse |

## Verification
Two functions can fall in the same cycle: a software write to a shadow threshold, and the reload of that shadow at the ceiling. The bench provokes this by waiting until its model shows the count one below the ceiling on the rising slope. It then issues a tick and a shadow write together.

The bench judges the result by the pin and the match flag over the next two periods. The period just started must use the value held before the write. The new value must appear only after the following ceiling. A second overlap comes when channel 0's threshold defines the ceiling: its match and the reload both fall on the ceiling step.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [2:0] {
        TOPSRC_FIX8  = 3'd0,
        TOPSRC_FIX9  = 3'd1,
        TOPSRC_FIX10 = 3'd2,
        TOPSRC_CAPT  = 3'd3,
        TOPSRC_CMPA  = 3'd4
    } top_src_e;

    localparam logic [1:0] OUT_OFF    = 2'd0;
    localparam logic [1:0] OUT_NONINV = 2'd2;
    localparam logic [1:0] OUT_INV    = 2'd3;

endpackage

// File: rtl/pwm_top_select.sv
module pwm_top_select
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_TOP = 3
) (
    input  logic [2:0]       src_i,
    input  logic [CNT_W-1:0] capt_i,
    input  logic [CNT_W-1:0] cmpa_i,
    output logic [CNT_W-1:0] top_o
);

    localparam logic [CNT_W-1:0] FIX8  = CNT_W'(255);
    localparam logic [CNT_W-1:0] FIX9  = CNT_W'(511);
    localparam logic [CNT_W-1:0] FIX10 = CNT_W'(1023);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TOP);

    logic [CNT_W-1:0] raw_top;

    always_comb begin
        case (src_i)
            TOPSRC_FIX9:  raw_top = FIX9;
            TOPSRC_FIX10: raw_top = FIX10;
            TOPSRC_CAPT:  raw_top = capt_i;
            TOPSRC_CMPA:  raw_top = cmpa_i;
            default:      raw_top = FIX8;
        endcase
        top_o = (raw_top < FLOOR) ? FLOOR : raw_top;
    end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic             up_nx_o,
    output logic             top_hit_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.ovf   = 1'b0;
        top_hit_o = 1'b0;
        if (tick_i) begin
            if (s_q.up) begin
                if (s_q.cnt >= top_i) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                    s_d.up  = 1'b0;
                end else begin
                    s_d.cnt   = s_q.cnt + CNT_W'(1);
                    s_d.up    = (s_d.cnt != top_i);
                    top_hit_o = (s_d.cnt == top_i);
                end
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                s_d.up  = (s_d.cnt == '0);
                s_d.ovf = (s_d.cnt == '0);
            end
        end
        cnt_nx_o = s_d.cnt;
        up_nx_o  = s_d.up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, up: 1'b1, ovf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign up_o  = s_q.up;
    assign ovf_o = s_q.ovf;

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)) || (cnt_o == $past(cnt_o) - CNT_W'(1)));

    a_r2_bottom_turns_up: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0) |-> up_o);

    a_r6_ovf_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o == '0) && $past(tick_i));

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       out_mode_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    input  logic             up_nx_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] act_o,
    output logic             pwm_o,
    output logic             match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] act;
        logic             pwm;
        logic             flag;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.flag = 1'b0;
        if (step_i && (cnt_nx_i == s_q.act)) begin
            s_d.flag = 1'b1;
            if (out_mode_i == OUT_NONINV) s_d.pwm = !up_nx_i;
            if (out_mode_i == OUT_INV)    s_d.pwm = up_nx_i;
        end
        if ((out_mode_i != OUT_NONINV) && (out_mode_i != OUT_INV)) s_d.pwm = 1'b0;
        if (load_i) s_d.act = s_q.shadow;
        if (wr_i)   s_d.shadow = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o   = s_q.act;
    assign pwm_o   = s_q.pwm;
    assign match_o = s_q.flag;

    a_r4_off_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i[1] == 1'b0) |=> !pwm_o);

    a_r7_flag_on_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (cnt_i == $past(act_o)));

    a_r9_active_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_o));

    a_r4_pin_moves_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && out_mode_i[1] && $stable(out_mode_i)) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
    import pwm_timer_pkg::*;
#(
    parameter int  CNT_W  = 16,
    parameter int  NUM_CH = 2,
    localparam int SEL_W  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [2:0]        top_src_i,
    input  logic [2*NUM_CH-1:0] out_mode_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              ovf_flag_o,
    output logic              capt_flag_o,
    output logic [NUM_CH-1:0] cmp_flag_o
);

    localparam logic [SEL_W-1:0] CAPT_SEL = SEL_W'(NUM_CH);

    typedef struct packed {
        logic [CNT_W-1:0] capt;
        logic             capf;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cnt_nx;
    logic             up_nx;
    logic             up_now;
    logic             top_hit;
    logic [CNT_W-1:0] act_val [NUM_CH];

    pwm_top_select #(.CNT_W(CNT_W)) u_topsel (
        .src_i  (top_src_i),
        .capt_i (s_q.capt),
        .cmpa_i (act_val[0]),
        .top_o  (top_val)
    );

    pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .top_i     (top_val),
        .cnt_o     (count_o),
        .up_o      (up_now),
        .cnt_nx_o  (cnt_nx),
        .up_nx_o   (up_nx),
        .top_hit_o (top_hit),
        .ovf_o     (ovf_flag_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_cmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .out_mode_i (out_mode_i[2*i +: 2]),
            .wr_i       (wr_en_i && (wr_sel_i == SEL_W'(i))),
            .wr_data_i  (wr_data_i),
            .step_i     (tick_i),
            .cnt_i      (count_o),
            .cnt_nx_i   (cnt_nx),
            .up_nx_i    (up_nx),
            .load_i     (top_hit),
            .act_o      (act_val[i]),
            .pwm_o      (pwm_o[i]),
            .match_o    (cmp_flag_o[i])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.capf = top_hit && (top_src_i == TOPSRC_CAPT);
        if (wr_en_i && (wr_sel_i == CAPT_SEL)) s_d.capt = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign capt_flag_o = s_q.capf;

    a_r8_capt_flag_at_turn: assert property (@(posedge clk) disable iff (!rst_n)
        capt_flag_o |-> !up_now && $past(up_now) && $past(tick_i));

    a_r8_capt_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
        capt_flag_o |-> (count_o == $past(top_val)));

    a_r6_ovf_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag_o |-> !$past(up_now));

endmodule

// File: tb/pwm_dual_slope_timer_tb.sv
module pwm_dual_slope_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int W   = 16;
    localparam int SW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_i = 1'b0;
    logic [2:0]      top_src_i = 3'd3;
    logic [2*NCH-1:0] out_mode_i = '0;
    logic            wr_en_i = 1'b0;
    logic [SW-1:0]   wr_sel_i = '0;
    logic [W-1:0]    wr_data_i = '0;
    logic [W-1:0]    count_o;
    logic [NCH-1:0]  pwm_o;
    logic            ovf_flag_o;
    logic            capt_flag_o;
    logic [NCH-1:0]  cmp_flag_o;

    pwm_dual_slope_timer #(.CNT_W(W), .NUM_CH(NCH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .top_src_i   (top_src_i),
        .out_mode_i  (out_mode_i),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .count_o     (count_o),
        .pwm_o       (pwm_o),
        .ovf_flag_o  (ovf_flag_o),
        .capt_flag_o (capt_flag_o),
        .cmp_flag_o  (cmp_flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int       cnt;
        bit [NCH-1:0] pwm;
        bit       ovf;
        bit [NCH-1:0] cmp;
        bit       capf;
    } exp_t;

    exp_t  exp_q[$];
    int    tests = 0;
    int    fails = 0;
    string phase = "R1";
    bit    done  = 1'b0;

    int        m_cnt = 0;
    bit        m_up  = 1'b1;
    int        m_buf [NCH];
    int        m_act [NCH];
    int        m_icr = 0;
    bit [NCH-1:0] m_pwm = '0;
    bit [2:0]  nxt_src = 3'd3;
    bit [2*NCH-1:0] nxt_mode = '0;

    task automatic check(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    function automatic int model_top();
        int t;
        case (nxt_src)
            3'd1: t = 511;
            3'd2: t = 1023;
            3'd3: t = m_icr;
            3'd4: t = m_act[0];
            default: t = 255;
        endcase
        if (t < 3) t = 3;
        return t;
    endfunction

    // driver: apply one clock of stimulus and push the expected result
    task automatic cyc(bit tk, bit we = 1'b0, int sel = 0, int data = 0);
        exp_t e;
        int   t;
        bit   topev;
        @(negedge clk);
        tick_i     = tk;
        wr_en_i    = we;
        wr_sel_i   = SW'(sel);
        wr_data_i  = W'(data);
        top_src_i  = nxt_src;
        out_mode_i = nxt_mode;
        t     = model_top();
        topev = 1'b0;
        e.ovf = 1'b0;
        e.cmp = '0;
        if (tk) begin
            if (m_up) begin
                if (m_cnt >= t) begin
                    m_cnt--; m_up = 1'b0;
                end else begin
                    m_cnt++; m_up = (m_cnt != t); topev = (m_cnt == t);
                end
            end else begin
                m_cnt--; m_up = (m_cnt == 0); e.ovf = m_up;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            bit [1:0] md;
            md = nxt_mode[2*i +: 2];
            if (tk && m_cnt == m_act[i]) begin
                e.cmp[i] = 1'b1;
                if (md == 2'd2) m_pwm[i] = !m_up;
                if (md == 2'd3) m_pwm[i] = m_up;
            end
            if (md < 2'd2) m_pwm[i] = 1'b0;
            if (topev) m_act[i] = m_buf[i];
        end
        e.capf = topev && (nxt_src == 3'd3);
        if (we) begin
            if (sel < NCH) m_buf[sel] = data;
            else           m_icr = data;
        end
        e.cnt = m_cnt;
        e.pwm = m_pwm;
        exp_q.push_back(e);
    endtask

    task automatic run(int n, bit gaps = 1'b0);
        for (int k = 0; k < n; k++) begin
            cyc(1'b1);
            if (gaps && (k % 3 == 1)) cyc(1'b0);
        end
    endtask

    task automatic wait_cnt(int v, bit up);
        for (int k = 0; k < 5000; k++) begin
            if (m_cnt == v && m_up == up) break;
            cyc(1'b1);
        end
    endtask

    // monitor: compare design outputs against queued expectations
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check("R2 count", int'(count_o), e.cnt);
                check("R4 pwm", int'(pwm_o), int'(e.pwm));
                check("R6 ovf flag", int'(ovf_flag_o), int'(e.ovf));
                check("R7 cmp flag", int'(cmp_flag_o), int'(e.cmp));
                check("R8 capture flag", int'(capt_flag_o), int'(e.capf));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin m_buf[i] = 0; m_act[i] = 0; end
        // R1: reset state
        phase = "R1 reset";
        repeat (3) @(negedge clk);
        check("count", int'(count_o), 0);
        check("pwm", int'(pwm_o), 0);
        check("flags", int'({ovf_flag_o, capt_flag_o, cmp_flag_o}), 0);
        rst_n = 1'b1;
        nxt_src  = 3'd3;
        nxt_mode = {2'd3, 2'd2};

        phase = "R9 shadow and capture writes";
        cyc(1'b0, 1'b1, 2, 6);
        cyc(1'b0, 1'b1, 0, 2);
        cyc(1'b0, 1'b1, 1, 4);
        phase = "R2 R4 R8 capture ceiling with gaps";
        run(40, 1'b1);

        phase = "R5 threshold above ceiling";
        cyc(1'b0, 1'b1, 1, 9);
        run(40);

        phase = "R9 write on ceiling step";
        wait_cnt(5, 1'b1);
        cyc(1'b1, 1'b1, 0, 3);
        run(40);

        phase = "R3 ceiling from channel 0";
        nxt_src = 3'd4;
        cyc(1'b0, 1'b1, 0, 8);
        run(50);

        phase = "R4 disconnected modes";
        nxt_mode = {2'd1, 2'd0};
        run(30);
        nxt_mode = {2'd2, 2'd3};

        phase = "R3 fixed 8-bit ceiling";
        nxt_src = 3'd0;
        cyc(1'b0, 1'b1, 0, 100);
        cyc(1'b0, 1'b1, 1, 200);
        run(600);

        phase = "R3 fixed 9-bit ceiling";
        nxt_src = 3'd1;
        run(1100);

        phase = "R3 fixed 10-bit ceiling";
        nxt_src = 3'd2;
        run(2100);

        phase = "R3 unused select acts as 8-bit";
        nxt_src = 3'd6;
        run(600);

        phase = "R10 ceiling lowered while rising";
        nxt_src = 3'd3;
        cyc(1'b0, 1'b1, 2, 100);
        wait_cnt(50, 1'b1);
        cyc(1'b0, 1'b1, 2, 10);
        run(40);

        phase = "R3 small ceiling clamped";
        cyc(1'b0, 1'b1, 2, 1);
        run(30);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule